// File: doc/BRIEF.md
# Bridge Configuration Request Router

This block is the configuration-request steering stage of a bridge or switch port. Requests arrive from the upstream side as records with a kind flag (Type 0 or Type 1), a bus number, device, function, dword register index, read/write flag, byte enables and write data. Each accepted request is resolved one clock later into exactly one result. The result is either a request passed on the downstream side or a completion returned to the requester.

The bridge keeps three bus-number bytes in one dword of its own header: the upstream bus, the bus directly below the port, and the highest bus reachable below it. A Type 0 request is always taken by the bridge itself, and software reads and writes these bytes through such requests. A Type 1 request is handled according to its target bus. If the target is the bus directly below, it is rewritten to Type 0 and passed down. If the target lies deeper in the range below, it is passed down unchanged. Any other target is refused with an Unsupported Request completion.

The downstream side is a point-to-point link. For that reason, a rewritten request may only address device 0 when the `P2P_ONLY` parameter is set. All three bus bytes clear on reset, so nothing is passed down until software has programmed them.

Top module: `cfg_bridge_router`

## Requirements
- R1: While reset is held and after its release, `dn_valid` and `cpl_valid` are 0, and the bus-number dword reads back as 0.
- R2: A request presented with `in_valid` high produces exactly one result on the next cycle: either `dn_valid` or `cpl_valid`, never both. No result appears in a cycle that follows an idle input cycle.
- R3: A Type 0 request (`in_type1`=0) is never passed down. It always yields a completion with status 2'b00 (success).
- R4: Own dword index `BUS_DWORD` (default 6) holds byte 0 = upstream bus, byte 1 = bus directly below, byte 2 = highest bus below, byte 3 = always reads 0. A Type 0 write updates only the bytes whose `in_be` bit is set. The new value governs every request from the next cycle on.
- R5: Own dword 0 reads {`DEVICE_ID`, `VENDOR_ID`}. Dword 3 reads 32'h0001_0000, which marks a bridge header. Every other dword reads 0, and writes to any dword other than `BUS_DWORD` leave every read-back value unchanged.
- R6: A Type 1 request whose bus equals the below-bus byte is passed down with `dn_type1`=0. Its bus, device, function, register, write flag, byte enables and data are unchanged (device must be 0 when `P2P_ONLY`=1).
- R7: With `P2P_ONLY`=1, a Type 1 request to the below-bus with a nonzero device gets a completion with status 2'b01 (Unsupported Request).
- R8: A Type 1 request whose bus is above the below-bus byte and no higher than the highest-bus byte is passed down with `dn_type1`=1 and all fields unchanged.
- R9: A Type 1 request whose bus is below the below-bus byte or above the highest-bus byte gets status 2'b01.
- R10: While the below-bus byte is 0, or the highest-bus byte is smaller than it, every Type 1 request gets status 2'b01.
- R11: Completions for writes and for refused requests carry `cpl_data` = 0. Completions for reads carry the read-back value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| in_type1 | input | 1 | 1 = Type 1 request, 0 = Type 0 |
| in_bus | input | 8 | Target bus number |
| in_dev | input | 5 | Target device number |
| in_fn | input | 3 | Target function number |
| in_reg | input | REG_W | Dword register index |
| in_wr | input | 1 | 1 = write, 0 = read |
| in_be | input | 4 | Byte enables |
| in_data | input | 32 | Write data |
| dn_valid | output | 1 | Request passed downstream |
| dn_type1 | output | 1 | Kind of the passed request |
| dn_bus | output | 8 | Passed bus number |
| dn_dev | output | 5 | Passed device number |
| dn_fn | output | 3 | Passed function number |
| dn_reg | output | REG_W | Passed register index |
| dn_wr | output | 1 | Passed write flag |
| dn_be | output | 4 | Passed byte enables |
| dn_data | output | 32 | Passed write data |
| cpl_valid | output | 1 | Completion returned |
| cpl_status | output | 2 | 2'b00 success, 2'b01 Unsupported Request |
| cpl_data | output | 32 | Completion read data |

## Verification
The routing decision is tried with target buses placed exactly on the below-bus, one past it, on the highest bus, one above the highest bus, and below the window. These placements separate off-by-one errors in each comparison. Device numbers 0 and nonzero at the below-bus separate the rewrite path from the point-to-point refusal. Bus bytes are reprogrammed with partial byte enables, back to back with routed traffic, and into closed configurations (below-bus 0, highest smaller than below). These cases show that the window follows the registers from the very next request and that a closed window refuses everything. A long pseudo-random mix of kinds, buses, devices, idles and writes is then compared cycle by cycle against a behavioural model.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;

    localparam int BUS_W  = 8;
    localparam int DEV_W  = 5;
    localparam int FN_W   = 3;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    typedef enum logic [1:0] {
        CPL_SC = 2'b00,
        CPL_UR = 2'b01
    } cpl_status_e;

    typedef enum logic [1:0] {
        RT_CLAIM,
        RT_CONVERT,
        RT_PASS,
        RT_REJECT
    } route_e;

endpackage

// File: rtl/cfg_bus_window.sv
module cfg_bus_window
    import cfg_route_pkg::*;
#(
    parameter bit P2P_ONLY = 1'b1
) (
    input  logic             req_type1,
    input  logic [BUS_W-1:0] req_bus,
    input  logic [DEV_W-1:0] req_dev,
    input  logic [BUS_W-1:0] sec_bus,
    input  logic [BUS_W-1:0] sub_bus,
    output route_e           route
);

    logic win_open;
    logic on_sec;
    logic in_deeper;
    logic dev_ok;

    // A window exists only when the below-bus is programmed and ordered.
    assign win_open  = (sec_bus != '0) && (sub_bus >= sec_bus);
    assign on_sec    = (req_bus == sec_bus);
    assign in_deeper = (req_bus > sec_bus) && (req_bus <= sub_bus);

    generate
        if (P2P_ONLY) begin : g_p2p
            assign dev_ok = (req_dev == '0);
        end else begin : g_shared
            assign dev_ok = 1'b1;
        end
    endgenerate

    always_comb begin
        if (!req_type1) begin
            route = RT_CLAIM;
        end else if (!win_open) begin
            route = RT_REJECT;
        end else if (on_sec) begin
            route = dev_ok ? RT_CONVERT : RT_REJECT;
        end else if (in_deeper) begin
            route = RT_PASS;
        end else begin
            route = RT_REJECT;
        end
    end

endmodule

// File: rtl/cfg_own_regs.sv
module cfg_own_regs
    import cfg_route_pkg::*;
#(
    parameter int          REG_W     = 10,
    parameter int          BUS_DWORD = 6,
    parameter logic [15:0] VENDOR_ID = 16'hABCD,
    parameter logic [15:0] DEVICE_ID = 16'h0123
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_wr,
    input  logic [REG_W-1:0]  acc_reg,
    input  logic [BE_W-1:0]   acc_be,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic [BUS_W-1:0]  pri_bus,
    output logic [BUS_W-1:0]  sec_bus,
    output logic [BUS_W-1:0]  sub_bus
);

    localparam int          NUM_LANES = 3;
    localparam int          HDR_DWORD = 3;
    localparam logic [31:0] HDR_VALUE = 32'h0001_0000;

    typedef struct packed {
        logic [NUM_LANES-1:0][BUS_W-1:0] num;
    } busregs_t;

    busregs_t regs_d, regs_q;
    logic     bus_hit;

    assign bus_hit = acc_valid && acc_wr && (acc_reg == REG_W'(BUS_DWORD));

    always_comb begin
        regs_d = regs_q;
        if (bus_hit) begin
            for (int lane = 0; lane < NUM_LANES; lane++) begin
                if (acc_be[lane]) begin
                    regs_d.num[lane] = acc_wdata[lane*8 +: BUS_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (acc_reg == REG_W'(0)) begin
            rd_data = {DEVICE_ID, VENDOR_ID};
        end else if (acc_reg == REG_W'(HDR_DWORD)) begin
            rd_data = HDR_VALUE;
        end else if (acc_reg == REG_W'(BUS_DWORD)) begin
            rd_data = {8'h00, regs_q.num[2], regs_q.num[1], regs_q.num[0]};
        end
    end

    assign pri_bus = regs_q.num[0];
    assign sec_bus = regs_q.num[1];
    assign sub_bus = regs_q.num[2];

    AST_BUSREG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && acc_wr && (acc_reg == REG_W'(BUS_DWORD))) |=> $stable(regs_q)); // R4

    AST_BUSREG_BE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_wr && !acc_be[1]) |=> $stable(sec_bus)); // R4

endmodule

// File: rtl/cfg_bridge_router.sv
module cfg_bridge_router
    import cfg_route_pkg::*;
#(
    parameter int          REG_W     = 10,
    parameter int          BUS_DWORD = 6,
    parameter bit          P2P_ONLY  = 1'b1,
    parameter logic [15:0] VENDOR_ID = 16'hABCD,
    parameter logic [15:0] DEVICE_ID = 16'h0123
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_type1,
    input  logic [7:0]        in_bus,
    input  logic [4:0]        in_dev,
    input  logic [2:0]        in_fn,
    input  logic [REG_W-1:0]  in_reg,
    input  logic              in_wr,
    input  logic [3:0]        in_be,
    input  logic [31:0]       in_data,
    output logic              dn_valid,
    output logic              dn_type1,
    output logic [7:0]        dn_bus,
    output logic [4:0]        dn_dev,
    output logic [2:0]        dn_fn,
    output logic [REG_W-1:0]  dn_reg,
    output logic              dn_wr,
    output logic [3:0]        dn_be,
    output logic [31:0]       dn_data,
    output logic              cpl_valid,
    output logic [1:0]        cpl_status,
    output logic [31:0]       cpl_data
);

    typedef struct packed {
        logic              dn_valid;
        logic              dn_type1;
        logic [BUS_W-1:0]  dn_bus;
        logic [DEV_W-1:0]  dn_dev;
        logic [FN_W-1:0]   dn_fn;
        logic [REG_W-1:0]  dn_reg;
        logic              dn_wr;
        logic [BE_W-1:0]   dn_be;
        logic [DATA_W-1:0] dn_data;
        logic              cpl_valid;
        cpl_status_e       cpl_status;
        logic [DATA_W-1:0] cpl_data;
    } out_t;

    out_t              out_d, out_q;
    route_e            route;
    logic [BUS_W-1:0]  pri_bus, sec_bus, sub_bus;
    logic [DATA_W-1:0] own_rd;
    logic              own_acc;

    cfg_bus_window #(
        .P2P_ONLY (P2P_ONLY)
    ) u_window (
        .req_type1 (in_type1),
        .req_bus   (in_bus),
        .req_dev   (in_dev),
        .sec_bus   (sec_bus),
        .sub_bus   (sub_bus),
        .route     (route)
    );

    assign own_acc = in_valid && (route == RT_CLAIM);

    cfg_own_regs #(
        .REG_W     (REG_W),
        .BUS_DWORD (BUS_DWORD),
        .VENDOR_ID (VENDOR_ID),
        .DEVICE_ID (DEVICE_ID)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (own_acc),
        .acc_wr    (in_wr),
        .acc_reg   (in_reg),
        .acc_be    (in_be),
        .acc_wdata (in_data),
        .rd_data   (own_rd),
        .pri_bus   (pri_bus),
        .sec_bus   (sec_bus),
        .sub_bus   (sub_bus)
    );

    always_comb begin
        out_d = '0;
        if (in_valid) begin
            unique case (route)
                RT_CLAIM: begin
                    out_d.cpl_valid  = 1'b1;
                    out_d.cpl_status = CPL_SC;
                    out_d.cpl_data   = in_wr ? '0 : own_rd;
                end
                RT_CONVERT, RT_PASS: begin
                    out_d.dn_valid = 1'b1;
                    out_d.dn_type1 = (route == RT_PASS);
                    out_d.dn_bus   = in_bus;
                    out_d.dn_dev   = in_dev;
                    out_d.dn_fn    = in_fn;
                    out_d.dn_reg   = in_reg;
                    out_d.dn_wr    = in_wr;
                    out_d.dn_be    = in_be;
                    out_d.dn_data  = in_data;
                end
                default: begin
                    out_d.cpl_valid  = 1'b1;
                    out_d.cpl_status = CPL_UR;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign dn_valid   = out_q.dn_valid;
    assign dn_type1   = out_q.dn_type1;
    assign dn_bus     = out_q.dn_bus;
    assign dn_dev     = out_q.dn_dev;
    assign dn_fn      = out_q.dn_fn;
    assign dn_reg     = out_q.dn_reg;
    assign dn_wr      = out_q.dn_wr;
    assign dn_be      = out_q.dn_be;
    assign dn_data    = out_q.dn_data;
    assign cpl_valid  = out_q.cpl_valid;
    assign cpl_status = out_q.cpl_status;
    assign cpl_data   = out_q.cpl_data;

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !(dn_valid && cpl_valid)); // R2

    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (dn_valid || cpl_valid)); // R2

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!dn_valid && !cpl_valid)); // R2

    AST_TYPE0_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_type1) |=> (cpl_valid && cpl_status == CPL_SC)); // R3

    AST_FWD_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_type1) |=> (!dn_valid ||
            (dn_bus == $past(in_bus) && dn_dev == $past(in_dev) && dn_reg == $past(in_reg)))); // R8

    AST_CONVERT_ON_SEC: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_type1 && in_bus == sec_bus && sec_bus != '0 && sub_bus >= sec_bus
         && in_dev == '0) |=> (dn_valid && !dn_type1)); // R6

    AST_WINDOW_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_type1 && sec_bus == '0) |=> (cpl_valid && cpl_status == CPL_UR)); // R10

    AST_UR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_status == CPL_UR) |-> (cpl_data == '0)); // R11

endmodule

// File: tb/sim_cfg_bridge_router.sv
module sim_cfg_bridge_router;

    localparam int  CLK_PERIOD = 10;
    localparam int  REG_W      = 10;
    localparam int  WATCHDOG   = 20000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_type1 = 1'b0;
    logic [7:0]       in_bus = '0;
    logic [4:0]       in_dev = '0;
    logic [2:0]       in_fn = '0;
    logic [REG_W-1:0] in_reg = '0;
    logic             in_wr = 1'b0;
    logic [3:0]       in_be = '0;
    logic [31:0]      in_data = '0;
    logic             dn_valid, dn_type1, dn_wr, cpl_valid;
    logic [7:0]       dn_bus;
    logic [4:0]       dn_dev;
    logic [2:0]       dn_fn;
    logic [REG_W-1:0] dn_reg;
    logic [3:0]       dn_be;
    logic [31:0]      dn_data, cpl_data;
    logic [1:0]       cpl_status;

    cfg_bridge_router #(.REG_W(REG_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_type1(in_type1),
        .in_bus(in_bus), .in_dev(in_dev), .in_fn(in_fn), .in_reg(in_reg),
        .in_wr(in_wr), .in_be(in_be), .in_data(in_data),
        .dn_valid(dn_valid), .dn_type1(dn_type1), .dn_bus(dn_bus), .dn_dev(dn_dev),
        .dn_fn(dn_fn), .dn_reg(dn_reg), .dn_wr(dn_wr), .dn_be(dn_be), .dn_data(dn_data),
        .cpl_valid(cpl_valid), .cpl_status(cpl_status), .cpl_data(cpl_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 0;

    // Behavioural reference state
    int m_pri = 0, m_sec = 0, m_sub = 0;
    // Expectation for the result due at the next sample
    bit          e_dn = 0, e_cpl = 0, e_t1 = 0, e_wr = 0;
    int          e_bus = 0, e_dev = 0, e_fn = 0, e_reg = 0, e_st = 0;
    logic [3:0]  e_be = '0;
    logic [31:0] e_data = '0, e_cdata = '0;
    string       e_tag = "R2";

    always @(posedge clk) cycles++;

    task automatic report();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        while (cycles < WATCHDOG && !finished) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, got %0d cycles expected < %0d", cycles, WATCHDOG);
            report();
        end
    end

    function automatic logic [31:0] model_read(int rg);
        if (rg == 0) return 32'h0123_ABCD;
        if (rg == 3) return 32'h0001_0000;
        if (rg == 6) return {8'h00, 8'(m_sub), 8'(m_sec), 8'(m_pri)};
        return 32'h0;
    endfunction

    task automatic compare();
        bit ok;
        ok = (dn_valid == e_dn) && (cpl_valid == e_cpl);
        if (ok && e_dn)
            ok = (dn_type1 == e_t1) && (dn_bus == 8'(e_bus)) && (dn_dev == 5'(e_dev)) &&
                 (dn_fn == 3'(e_fn)) && (dn_reg == REG_W'(e_reg)) && (dn_wr == e_wr) &&
                 (dn_be == e_be) && (dn_data == e_data);
        if (ok && e_cpl)
            ok = (cpl_status == 2'(e_st)) && (cpl_data == e_cdata);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s t=%0t: got dn=%0d t1=%0d bus=%0d dev=%0d cpl=%0d st=%0d cdata=%h expected dn=%0d t1=%0d bus=%0d dev=%0d cpl=%0d st=%0d cdata=%h",
                     e_tag, $time, dn_valid, dn_type1, dn_bus, dn_dev, cpl_valid, cpl_status, cpl_data,
                     e_dn, e_t1, e_bus, e_dev, e_cpl, e_st, e_cdata);
        end
    endtask

    // One clock: check the result due now, then present the next request.
    task automatic step(input bit v, input bit t1, input int bus, input int dev, input int fn,
                        input int rg, input bit wr, input logic [3:0] be, input logic [31:0] dat,
                        input string tg);
        bit open;
        @(negedge clk);
        compare();
        in_valid = v; in_type1 = t1; in_bus = 8'(bus); in_dev = 5'(dev); in_fn = 3'(fn);
        in_reg = REG_W'(rg); in_wr = wr; in_be = be; in_data = dat;
        e_dn = 0; e_cpl = 0; e_t1 = t1; e_bus = bus; e_dev = dev; e_fn = fn; e_reg = rg;
        e_wr = wr; e_be = be; e_data = dat; e_st = 0; e_cdata = '0; e_tag = "R2";
        if (v) begin
            if (!t1) begin
                e_cpl = 1; e_st = 0;                       // R3 success
                e_cdata = wr ? 32'h0 : model_read(rg);     // R11
                e_tag = wr ? "R11" : (rg == 6 ? "R4" : "R5");
                if (wr && rg == 6) begin
                    if (be[0]) m_pri = int'(dat[7:0]);
                    if (be[1]) m_sec = int'(dat[15:8]);
                    if (be[2]) m_sub = int'(dat[23:16]);
                end
            end else begin
                open = (m_sec != 0) && (m_sub >= m_sec);
                if (!open) begin
                    e_cpl = 1; e_st = 1; e_tag = "R10";
                end else if (bus == m_sec && dev == 0) begin
                    e_dn = 1; e_t1 = 0; e_tag = "R6";
                end else if (bus == m_sec) begin
                    e_cpl = 1; e_st = 1; e_tag = "R7";
                end else if (bus > m_sec && bus <= m_sub) begin
                    e_dn = 1; e_t1 = 1; e_tag = "R8";
                end else begin
                    e_cpl = 1; e_st = 1; e_tag = "R9";
                end
            end
        end
        if (tg != "") e_tag = tg;
    endtask

    task automatic t0rd(input int rg, input string tg);
        step(1, 0, 0, 0, 0, rg, 0, 4'hF, 32'h0, tg);
    endtask

    task automatic t0wr(input int rg, input logic [3:0] be, input logic [31:0] d);
        step(1, 0, 0, 0, 0, rg, 1, be, d, "");
    endtask

    task automatic t1rq(input int bus, input int dev, input int fn, input int rg, input bit wr);
        step(1, 1, bus, dev, fn, rg, wr, 4'b0011, 32'hC0DE_0000 + 32'(bus), "");
    endtask

    logic [31:0] lf = 32'h1234_5678;

    initial begin
        // R1: outputs idle during reset
        repeat (3) @(negedge clk);
        total++;
        if (dn_valid !== 1'b0 || cpl_valid !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset: got dn=%0d cpl=%0d expected 0 0", dn_valid, cpl_valid);
        end
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
        t0rd(6, "R1");                          // bus bytes cleared by reset
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
        // R10: nothing forwarded before programming
        t1rq(0, 0, 0, 0, 0);
        t1rq(3, 0, 1, 4, 0);
        // R5: identity, header, other dwords, ignored writes
        t0rd(0, "R5");
        t0rd(3, "R5");
        t0rd(7, "R5");
        t0wr(7, 4'hF, 32'hFFFF_FFFF);
        t0wr(3, 4'hF, 32'hFFFF_FFFF);
        t0rd(7, "R5");
        t0rd(3, "R5");
        t0rd(6, "R5");
        // R4: program Pri=4 Sec=5 Sub=5, byte 3 stays zero
        t0wr(6, 4'hF, 32'hAA05_0504);
        t0rd(6, "R4");
        // R6 / R7 at the below-bus
        t1rq(5, 0, 0, 0, 0);
        t1rq(5, 0, 3, 16, 1);
        t1rq(5, 2, 0, 0, 0);
        t1rq(5, 31, 7, 0, 1);
        // R9 neighbours of a one-bus window
        t1rq(4, 0, 0, 0, 0);
        t1rq(6, 0, 0, 0, 0);
        // R4: partial byte enables reshape the window to Sec=2 Sub=6
        t0wr(6, 4'b0010, 32'hFFFF_02FF);
        t0wr(6, 4'b0100, 32'h0006_0000);
        t0rd(6, "R4");
        // R8 deeper buses and R9 edges
        t1rq(3, 4, 1, 2, 0);
        t1rq(6, 9, 2, 3, 1);
        t1rq(7, 0, 0, 0, 0);
        t1rq(1, 0, 0, 0, 0);
        t1rq(255, 0, 0, 0, 0);
        t1rq(2, 0, 5, 1023, 0);
        // R4: back-to-back write then route with new value
        t0wr(6, 4'b0010, 32'h0000_0300);
        t1rq(3, 0, 0, 0, 0);
        t1rq(2, 0, 0, 0, 0);
        // R10: highest below the below-bus closes the window
        t0wr(6, 4'b0110, 32'h0003_0900);
        t1rq(9, 0, 0, 0, 0);
        t1rq(3, 0, 0, 0, 0);
        // R10: below-bus zero closes the window
        t0wr(6, 4'b0110, 32'h0008_0000);
        t1rq(0, 0, 0, 0, 0);
        t1rq(4, 0, 0, 0, 0);
        t0wr(6, 4'hF, 32'h0006_0201);
        // Pseudo-random mix compared every cycle
        for (int i = 0; i < 600; i++) begin
            lf = lf * 32'd1664525 + 32'd1013904223;
            if (lf[31] & lf[30]) begin
                step(0, 0, 0, 0, 0, 0, 0, 0, 0, "");
            end else if (lf[0] | lf[1]) begin
                step(1, 1, int'(lf[10:8]), lf[12] ? int'(lf[14:13]) : 0, int'(lf[17:15]),
                     int'(lf[23:18]), lf[24], lf[28:25], lf ^ 32'h5A5A_0000, "");
            end else begin
                step(1, 0, 0, 0, 0, lf[5] ? 6 : int'(lf[4:2]),
                     lf[20] & lf[21] & lf[22], lf[27:24],
                     {8'h00, 5'h0, lf[14:12], 5'h0, lf[11:9], lf[15:8]}, "");
            end
        end
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "");
        finished = 1;
        report();
    end

endmodule